// File: doc/BRIEF.md
# Zero-Substitution Line Decoder with Violation Flag

This block sits behind a receive line interface that has already recovered the bit clock. It takes retimed dual-rail AMI data: one positive-mark bit and one negative-mark bit per recovered clock. It looks for zero-substitution code words in that stream. The code set is picked by a rate select: the eight-bit B8ZS word on the lower rate, and the four-bit HDB3 words on the higher rate.

When suppression is enabled, every recognised code word leaves the block as zeros on both rails. When suppression is off, the stream passes through unaltered. Alongside the data, a violation flag marks each output bit that breaks mark alternation.

Both rails travel through a fixed delay line so that a whole code word is visible before its first bit is released. The output rails and the flag are registered and aligned to one another.

Top module: `ami_subst_decoder`

## Requirements
- R1: While reset is asserted, out_pos, out_neg and bpv are all low. The stored last-mark polarity is then negative, and the delay line is cleared.
- R2: A bit sampled on a rising clock edge appears on out_pos/out_neg, together with its bpv value, DEPTH+1 edges later (9 at the default DEPTH of 8), unchanged when it belongs to no code word.
- R3: With rate_sel low and zcs_en high, the sequence 0,0,0,V,B,0,V,B is replaced by eight all-zero output bits. Here a mark is (in_pos,in_neg)=(1,0) for positive or (0,1) for negative, V is a mark of the same polarity as the mark before the word, and B is a mark of the opposite polarity to the mark just before it.
- R4: With rate_sel high and zcs_en high, both 0,0,0,V and B,0,0,V are replaced by four all-zero output bits. In 0,0,0,V, V has the polarity of the mark before the word. In B,0,0,V, B is opposite to the mark before the word and V equals B.
- R5: With zcs_en low, code words of either kind leave the block exactly as received.
- R6: bpv is high for exactly the one output bit that is a single-rail mark with the same polarity as the previous mark, and low on zeros and alternating marks.
- R7: A bit with both rails high is output unchanged with bpv high, and it does not change the stored last-mark polarity.
- R8: With zcs_en high and rate_sel low, no bit of a B8ZS word raises bpv. With zcs_en low, the two V bits of such a word raise bpv.
- R9: After reset, the first single-rail mark is judged against a negative previous mark: a negative first mark raises bpv and a positive one does not.
- R10: rate_sel selects the code set: with rate_sel low, a 0,0,0,V group that is not part of a B8ZS word passes unchanged even with zcs_en high.
- R11: Two B8ZS words received back to back are both replaced by zeros, with no bit left over between them.
- R12: With rate_sel and zcs_en both high, the value of bpv is not specified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 1 | 0: B8ZS code words, 1: HDB3 code words |
| zcs_en | input | 1 | 1: replace recognised code words by zeros |
| in_pos | input | 1 | Positive-mark rail of the incoming bit |
| in_neg | input | 1 | Negative-mark rail of the incoming bit |
| out_pos | output | 1 | Delayed positive-mark rail |
| out_neg | output | 1 | Delayed negative-mark rail |
| bpv | output | 1 | Violation flag aligned with the output bit |

## Verification
The hardest situation to reach from the ports is a code word whose match depends on a polarity set by marks that have already left the delay line. The back-to-back word pair, where the second word's reference comes from the last bit of the first word, is the sharpest case of this. The stimulus primes the polarity with a chosen lone mark and then drives two identical words without a gap. It also drives an HDB3 group under the B8ZS setting, so that only the rate select decides the result. Each change of mode is preceded by a zero flush under the old mode, so no word ever straddles two settings.

// File: rtl/ami_dec_pkg.sv
package ami_dec_pkg;

    // One line symbol: p is the positive-mark rail, n the negative-mark rail.
    typedef struct packed {
        logic p;
        logic n;
    } rail_t;

    // Delay-line slot: the symbol plus "already claimed by a code word".
    typedef struct packed {
        rail_t sym;
        logic  word;
    } slot_t;

    localparam int B8_LEN = 8;  // long substitution word length
    localparam int HD_LEN = 4;  // short substitution word length

    localparam rail_t SYM_ZERO = 2'b00;
    localparam rail_t SYM_POS  = 2'b10;
    localparam rail_t SYM_NEG  = 2'b01;

endpackage

// File: rtl/ami_dec_pipe.sv
module ami_dec_pipe
    import ami_dec_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIN   = B8_LEN
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  rail_t                din,
    input  logic [WIN-2:0]       claim_up,
    output rail_t [WIN-1:0]      win_sym,
    output logic                 head_word
);

    typedef struct packed {
        slot_t [DEPTH-1:0] slots;
    } pipe_st_t;

    pipe_st_t st_d, st_q;
    logic [DEPTH-1:0] claim_ext;

    always_comb begin
        claim_ext            = '0;
        claim_ext[WIN-2:0]   = claim_up;
        st_d                 = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (i == DEPTH - 1) begin
                st_d.slots[i].sym  = din;
                st_d.slots[i].word = 1'b0;
            end else begin
                st_d.slots[i].sym  = st_q.slots[i+1].sym;
                st_d.slots[i].word = st_q.slots[i+1].word | claim_ext[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < WIN; g++) begin : g_win
        assign win_sym[g] = st_q.slots[g].sym;
    end

    assign head_word = st_q.slots[0].word;

endmodule

// File: rtl/ami_dec_match.sv
module ami_dec_match
    import ami_dec_pkg::*;
(
    input  rail_t [B8_LEN-1:0] win,
    input  logic               last_pos,
    input  logic               head_busy,
    input  logic               rate_sel,
    output logic [B8_LEN-1:0]  claim
);

    rail_t same_m, opp_m;
    logic  hit_b8, hit_hd_zero, hit_hd_bal, hit_hd;

    always_comb begin
        same_m = last_pos ? SYM_POS : SYM_NEG;
        opp_m  = last_pos ? SYM_NEG : SYM_POS;

        hit_b8 = (win[0] == SYM_ZERO) && (win[1] == SYM_ZERO) &&
                 (win[2] == SYM_ZERO) && (win[3] == same_m)   &&
                 (win[4] == opp_m)    && (win[5] == SYM_ZERO) &&
                 (win[6] == opp_m)    && (win[7] == same_m);

        hit_hd_zero = (win[0] == SYM_ZERO) && (win[1] == SYM_ZERO) &&
                      (win[2] == SYM_ZERO) && (win[3] == same_m);
        hit_hd_bal  = (win[0] == opp_m)    && (win[1] == SYM_ZERO) &&
                      (win[2] == SYM_ZERO) && (win[3] == opp_m);
        hit_hd      = hit_hd_zero || hit_hd_bal;
    end

    for (genvar g = 0; g < B8_LEN; g++) begin : g_claim
        if (g < HD_LEN) begin : g_both
            assign claim[g] = !head_busy && (rate_sel ? hit_hd : hit_b8);
        end else begin : g_long
            assign claim[g] = !head_busy && !rate_sel && hit_b8;
        end
    end

endmodule

// File: rtl/ami_dec_judge.sv
module ami_dec_judge
    import ami_dec_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  zcs_en,
    input  rail_t head,
    input  logic  in_word,
    output logic  out_pos,
    output logic  out_neg,
    output logic  bpv,
    output logic  last_pos
);

    typedef struct packed {
        rail_t out;
        logic  viol;
        logic  last_pos;
    } judge_st_t;

    judge_st_t st_d, st_q;
    logic zap, single, clash;

    always_comb begin
        st_d   = st_q;
        zap    = zcs_en && in_word;
        single = head.p ^ head.n;
        clash  = (head.p && head.n) ||
                 (head.p && st_q.last_pos) ||
                 (head.n && !st_q.last_pos);

        st_d.out      = zap ? SYM_ZERO : head;
        st_d.viol     = clash && !zap;
        st_d.last_pos = single ? head.p : st_q.last_pos;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;   // last_pos = 0: previous mark negative
        else        st_q <= st_d;
    end

    assign out_pos  = st_q.out.p;
    assign out_neg  = st_q.out.n;
    assign bpv      = st_q.viol;
    assign last_pos = st_q.last_pos;

endmodule

// File: rtl/ami_subst_decoder.sv
module ami_subst_decoder
    import ami_dec_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_sel,
    input  logic zcs_en,
    input  logic in_pos,
    input  logic in_neg,
    output logic out_pos,
    output logic out_neg,
    output logic bpv
);

    localparam int WIN = B8_LEN;

    rail_t             din;
    rail_t [WIN-1:0]   win_sym;
    logic  [WIN-1:0]   claim;
    logic              head_word;
    logic              head_in_word;
    logic              last_pos;
    rail_t             head_sym;

    assign din.p        = in_pos;
    assign din.n        = in_neg;
    assign head_sym     = win_sym[0];
    assign head_in_word = head_word || claim[0];

    ami_dec_pipe #(.DEPTH(DEPTH), .WIN(WIN)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .claim_up  (claim[WIN-1:1]),
        .win_sym   (win_sym),
        .head_word (head_word)
    );

    ami_dec_match u_match (
        .win       (win_sym),
        .last_pos  (last_pos),
        .head_busy (head_word),
        .rate_sel  (rate_sel),
        .claim     (claim)
    );

    ami_dec_judge u_judge (
        .clk      (clk),
        .rst_n    (rst_n),
        .zcs_en   (zcs_en),
        .head     (head_sym),
        .in_word  (head_in_word),
        .out_pos  (out_pos),
        .out_neg  (out_neg),
        .bpv      (bpv),
        .last_pos (last_pos)
    );

endmodule

// File: rtl/ami_subst_decoder_chk.sv
module ami_subst_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       zcs_en,
    input logic [1:0] head_sym,
    input logic       head_in_word,
    input logic       out_pos,
    input logic       out_neg,
    input logic       bpv
);

    // R3 R4
    word_zeroed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(zcs_en && head_in_word) |-> (!out_pos && !out_neg));

    // R5
    transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(zcs_en) |-> ({out_pos, out_neg} == $past(head_sym)));

    // R6
    flag_on_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bpv |-> (out_pos || out_neg));

    // R7
    dual_rail_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_pos && out_neg) |-> bpv);

    // R8
    word_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(zcs_en && head_in_word) |-> !bpv);

endmodule

bind ami_subst_decoder ami_subst_decoder_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .zcs_en       (zcs_en),
    .head_sym     (head_sym),
    .head_in_word (head_in_word),
    .out_pos      (out_pos),
    .out_neg      (out_neg),
    .bpv          (bpv)
);

// File: tb/ami_subst_decoder_bench.sv
module ami_subst_decoder_bench;

    localparam int DEPTH = 8;
    localparam int LAT   = DEPTH + 1;
    localparam int NV    = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rate_sel = 1'b0, zcs_en = 1'b0, in_pos = 1'b0, in_neg = 1'b0;
    logic out_pos, out_neg, bpv;

    int total = 0;
    int bad   = 0;

    // expected history: {exp_pos, exp_neg, exp_bpv, check_bpv}, tag
    logic [3:0] hist [LAT];
    int         htag [LAT];

    always #2 clk = ~clk;

    ami_subst_decoder #(.DEPTH(DEPTH)) u_ami_subst_decoder (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .zcs_en(zcs_en),
        .in_pos(in_pos), .in_neg(in_neg),
        .out_pos(out_pos), .out_neg(out_neg), .bpv(bpv)
    );

    // entry: [11:8] requirement, [7] rate, [6] zcs, [5] pos, [4] neg,
    //        [3] exp pos, [2] exp neg, [1] exp bpv, [0] check bpv
    localparam logic [11:0] VEC [NV] = '{
        // B8ZS, suppression on; previous mark starts negative
        {4'd9,  8'b01_10_10_01},  // R9 first positive mark, no flag
        {4'd6,  8'b01_01_01_01},  // R6
        {4'd6,  8'b01_01_01_11},  // R6 repeated negative
        {4'd2,  8'b01_00_00_01},  // R2
        {4'd6,  8'b01_10_10_01},  // R6 reference now positive
        {4'd3,  8'b01_00_00_01}, {4'd3, 8'b01_00_00_01}, {4'd3, 8'b01_00_00_01}, // R3
        {4'd3,  8'b01_10_00_01}, {4'd8, 8'b01_01_00_01}, {4'd3, 8'b01_00_00_01}, // R8
        {4'd8,  8'b01_01_00_01}, {4'd3, 8'b01_10_00_01},
        {4'd11, 8'b01_00_00_01}, {4'd11, 8'b01_00_00_01}, {4'd11, 8'b01_00_00_01}, // R11
        {4'd11, 8'b01_10_00_01}, {4'd11, 8'b01_01_00_01}, {4'd11, 8'b01_00_00_01},
        {4'd11, 8'b01_01_00_01}, {4'd11, 8'b01_10_00_01},
        {4'd6,  8'b01_10_10_11},  // R6 positive after positive
        {4'd7,  8'b01_11_11_11},  // R7 both rails
        {4'd7,  8'b01_01_01_01},  // R7 reference kept positive
        // B8ZS, suppression off; reference negative
        {4'd5,  8'b00_00_00_01}, {4'd5, 8'b00_00_00_01}, {4'd5, 8'b00_00_00_01}, // R5
        {4'd8,  8'b00_01_01_11}, {4'd5, 8'b00_10_10_01}, {4'd5, 8'b00_00_00_01},
        {4'd8,  8'b00_10_10_11}, {4'd5, 8'b00_01_01_01},
        // B8ZS, suppression on, short group only; reference negative
        {4'd10, 8'b01_00_00_01}, {4'd10, 8'b01_00_00_01}, {4'd10, 8'b01_00_00_01}, // R10
        {4'd10, 8'b01_01_01_11},
        // HDB3, suppression on; flag unchecked (R12)
        {4'd4,  8'b11_10_10_00},  // R4 lone mark
        {4'd4,  8'b11_00_00_00}, {4'd4, 8'b11_00_00_00}, {4'd4, 8'b11_00_00_00},
        {4'd4,  8'b11_10_00_00},  // R4 000V removed
        {4'd4,  8'b11_01_01_00},
        {4'd4,  8'b11_10_00_00}, {4'd4, 8'b11_00_00_00}, {4'd4, 8'b11_00_00_00},
        {4'd4,  8'b11_10_00_00},  // R4 B00V removed
        // HDB3, suppression off; reference positive
        {4'd5,  8'b10_00_00_01}, {4'd5, 8'b10_00_00_01}, {4'd5, 8'b10_00_00_01},
        {4'd5,  8'b10_10_10_11}   // R5 V passes and is flagged
    };

    task automatic step(input logic r, input logic z, input logic p, input logic n,
                        input logic [3:0] expv, input int tag);
        rate_sel = r; zcs_en = z; in_pos = p; in_neg = n;
        for (int i = LAT - 1; i > 0; i--) begin
            hist[i] = hist[i-1];
            htag[i] = htag[i-1];
        end
        hist[0] = expv;
        htag[0] = tag;
        @(posedge clk);
        @(negedge clk);
        total++;
        if (out_pos !== hist[LAT-1][3] || out_neg !== hist[LAT-1][2] ||
            (hist[LAT-1][0] && bpv !== hist[LAT-1][1])) begin
            bad++;
            $display("FAIL R%0d: got pos=%b neg=%b bpv=%b, expected pos=%b neg=%b bpv=%b",
                     htag[LAT-1], out_pos, out_neg, bpv,
                     hist[LAT-1][3], hist[LAT-1][2], hist[LAT-1][1]);
        end
    endtask

    task automatic flush(input logic r, input logic z);
        for (int k = 0; k < LAT; k++) step(r, z, 1'b0, 1'b0, 4'b0001, 2);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_pos = 1'b1; in_neg = 1'b0;
        for (int i = 0; i < LAT; i++) begin
            hist[i] = 4'b0001;
            htag[i] = 2;
        end
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
            total++;   // R1
            if (out_pos !== 1'b0 || out_neg !== 1'b0 || bpv !== 1'b0) begin
                bad++;
                $display("FAIL R1: got pos=%b neg=%b bpv=%b, expected 0 0 0",
                         out_pos, out_neg, bpv);
            end
        end
        in_pos = 1'b0;
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        // R1 and R9: first negative mark after reset is a violation
        do_reset();
        step(1'b0, 1'b0, 1'b0, 1'b1, 4'b0111, 9);
        flush(1'b0, 1'b0);

        // R2: a mark emerges exactly LAT edges later, zeros around it
        do_reset();
        step(1'b0, 1'b0, 1'b1, 1'b0, 4'b1001, 2);
        flush(1'b0, 1'b0);

        // vector table, flushing under the old mode before each mode change
        do_reset();
        for (int i = 0; i < NV; i++) begin
            if (i > 0 && VEC[i][7:6] != VEC[i-1][7:6])
                flush(VEC[i-1][7], VEC[i-1][6]);
            step(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3:0],
                 int'(VEC[i][11:8]));
        end
        flush(VEC[NV-1][7], VEC[NV-1][6]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule